// File: doc/BRIEF.md
# Address Region Bounds Checker

This block watches every data-memory address a processor core issues and decides whether it falls inside one of three software-maintained windows: global data, heap and stack. An address that lands in none of them is treated as a symptom of a hardware fault. A corrupted address often points into an unallocated hole of a page that is otherwise mapped, and such an address would otherwise go unnoticed for a long time. The windows are not fixed at reset. A loader writes the global-data window once, before the program starts. The allocator moves the heap top each time it hands out memory. Call and return code rewrites the stack window.

The limits, a checker enable bit and a flag-clear command all share one small write port, which is addressed by a select code. The first out-of-window access raises a sticky flag and captures its address. Every out-of-window access, the first one included, bumps a saturating count. Page tables, permission checks and trap delivery lie outside this block.

Top module: `addr_bounds_chk`

## Requirements
- R1: Each of the three regions (global, heap, stack) is checked on its own. An enabled access whose address lies inside any non-empty region raises no violation and leaves the count unchanged.
- R2: While the checker is enabled, an access with `acc_vld`=1 whose address lies outside every region sets `viol_flag` and raises `viol_cnt` by one. Both are visible after the clock edge that samples the access.
- R3: A region covers `lo <= addr < hi`. The lower limit is inside the region and the upper limit is outside it.
- R4: A region whose lower limit is greater than or equal to its upper limit is empty and matches no address.
- R5: A limit write on `cfg_wr` with `cfg_sel` 0..5 applies to accesses presented from the next cycle on. An access presented in the same cycle as the write is judged against the old limit. Select codes: 0 global low, 1 global high, 2 heap low, 3 heap high, 4 stack low, 5 stack high.
- R6: The first violation while the flag is clear latches its address on `viol_addr`. Later violations leave the flag set and the address unchanged.
- R7: `viol_cnt` is 16 bits wide and stops at 65535. Further violations leave it at 65535.
- R8: A write with `cfg_sel`=7 clears `viol_flag` and leaves `viol_cnt` unchanged. If a violation arrives in the same cycle as the clear, the flag stays set and `viol_addr` takes the new address.
- R9: A write with `cfg_sel`=6 loads the enable from `cfg_data[0]`. While the enable is 0, no access changes the flag, the address or the count.
- R10: After reset the flag, address and count are 0, the checker is disabled, and every region is empty because all of its limits are 0.
- R11: Addresses are compared as unsigned 64-bit values across the whole span from 0 to 2^64-1, so limits near the top of the space behave the same as limits near zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | A data access is presented this cycle |
| acc_addr | input | 64 | Address of the presented access |
| cfg_wr | input | 1 | Write strobe for the limit and control port |
| cfg_sel | input | 3 | Target of the write: 0..5 limits, 6 enable, 7 clear flag |
| cfg_data | input | 64 | Write data |
| viol_flag | output | 1 | Sticky flag for an out-of-window access |
| viol_addr | output | 64 | Address of the first violation since the last clear |
| viol_cnt | output | 16 | Saturating count of violations |

## Verification
The assertions run on every cycle. They check that an in-window access or a disabled checker never moves the count, and that an enabled miss raises the count by exactly one until it saturates. They also check that the flag rises only after an enabled access, and that a held flag keeps its address until a clear. What only the bench scenarios can show are the exact window edges (inclusive low limit, exclusive high limit, limits near 2^64-1), empty windows, the one-cycle delay before a limit write takes effect, and a violation racing a clear. Those checks depend on the values software writes, and a simple cycle-to-cycle property cannot follow those values.

// File: rtl/abc_pkg.sv
package abc_pkg;
  localparam int unsigned ABC_ADDR_W = 64;
  localparam int unsigned ABC_CNT_W  = 16;
  localparam int unsigned ABC_NUM_RGN = 3;

  typedef enum logic [1:0] {
    RGN_GLOBAL = 2'd0,
    RGN_HEAP   = 2'd1,
    RGN_STACK  = 2'd2
  } rgn_id_e;
endpackage

// File: rtl/abc_limits.sv
module abc_limits #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned NUM_RGN = 3,
  parameter int unsigned SEL_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_wr,
  input  logic [SEL_W-1:0]                 cfg_sel,
  input  logic [ADDR_W-1:0]                cfg_data,
  output logic [NUM_RGN-1:0][ADDR_W-1:0]   lo_q,
  output logic [NUM_RGN-1:0][ADDR_W-1:0]   hi_q,
  output logic                             en_q
);
  localparam int unsigned CTRL_CODE = 2 * NUM_RGN;

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    localparam int unsigned LO_CODE = 2 * r;
    localparam int unsigned HI_CODE = 2 * r + 1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[r] <= '0;
        hi_q[r] <= '0;
      end else if (cfg_wr) begin
        if (cfg_sel == SEL_W'(LO_CODE)) lo_q[r] <= cfg_data;
        if (cfg_sel == SEL_W'(HI_CODE)) hi_q[r] <= cfg_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                       en_q <= 1'b0;
    else if (cfg_wr && cfg_sel == SEL_W'(CTRL_CODE))  en_q <= cfg_data[0];
  end
endmodule

// File: rtl/abc_region_cmp.sv
module abc_region_cmp #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned NUM_RGN = 3
) (
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_RGN-1:0][ADDR_W-1:0]   lo,
  input  logic [NUM_RGN-1:0][ADDR_W-1:0]   hi,
  output logic [NUM_RGN-1:0]               rgn_hit,
  output logic                             hit_any
);
  // Half-open window; lo >= hi yields an empty window.
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] w_lo,
                                     input logic [ADDR_W-1:0] w_hi);
    logic non_empty;
    non_empty = (w_lo < w_hi);
    return non_empty && (a >= w_lo) && (a < w_hi);
  endfunction

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_cmp
    assign rgn_hit[r] = in_window(addr, lo[r], hi[r]);
  end

  assign hit_any = |rgn_hit;
endmodule

// File: rtl/abc_viol_log.sv
module abc_viol_log #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol_now,
  input  logic              clr_now,
  input  logic [ADDR_W-1:0] addr,
  output logic              flag_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + CNT_W'(1);
  endfunction

  logic capture;
  assign capture = viol_now && (!flag_q || clr_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (viol_now)     flag_q <= 1'b1;
      else if (clr_now) flag_q <= 1'b0;
      if (capture)      addr_q <= addr;
      if (viol_now)     cnt_q  <= sat_inc(cnt_q);
    end
  end
endmodule

// File: rtl/addr_bounds_chk.sv
module addr_bounds_chk
  import abc_pkg::*;
#(
  parameter int unsigned ADDR_W  = ABC_ADDR_W,
  parameter int unsigned CNT_W   = ABC_CNT_W,
  parameter int unsigned NUM_RGN = ABC_NUM_RGN,
  localparam int unsigned SEL_W  = $clog2(2 * NUM_RGN + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  output logic              viol_flag,
  output logic [ADDR_W-1:0] viol_addr,
  output logic [CNT_W-1:0]  viol_cnt
);
  localparam int unsigned CLR_CODE = 2 * NUM_RGN + 1;

  logic [NUM_RGN-1:0][ADDR_W-1:0] lo_q;
  logic [NUM_RGN-1:0][ADDR_W-1:0] hi_q;
  logic                           en_q;
  logic [NUM_RGN-1:0]             rgn_hit;
  logic                           hit_any;
  logic                           viol_now;
  logic                           clr_now;

  abc_limits #(.ADDR_W(ADDR_W), .NUM_RGN(NUM_RGN), .SEL_W(SEL_W)) u_limits (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .lo_q(lo_q), .hi_q(hi_q), .en_q(en_q)
  );

  abc_region_cmp #(.ADDR_W(ADDR_W), .NUM_RGN(NUM_RGN)) u_cmp (
    .addr(acc_addr), .lo(lo_q), .hi(hi_q), .rgn_hit(rgn_hit), .hit_any(hit_any)
  );

  assign viol_now = acc_vld && en_q && !hit_any;
  assign clr_now  = cfg_wr && (cfg_sel == SEL_W'(CLR_CODE));

  abc_viol_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
    .clk(clk), .rst_n(rst_n), .viol_now(viol_now), .clr_now(clr_now),
    .addr(acc_addr), .flag_q(viol_flag), .addr_q(viol_addr), .cnt_q(viol_cnt)
  );
endmodule

// File: rtl/abc_chk.sv
module abc_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_vld,
  input logic              en_q,
  input logic              hit_any,
  input logic              clr_now,
  input logic              viol_flag,
  input logic [ADDR_W-1:0] viol_addr,
  input logic [CNT_W-1:0]  viol_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_hit_no_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && hit_any) |=> $stable(viol_cnt));

  assert_miss_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && en_q && !hit_any && viol_cnt != CNT_MAX)
      |=> (viol_cnt == $past(viol_cnt) + CNT_W'(1)) && viol_flag);

  assert_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flag) |-> $past(acc_vld && en_q));

  assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !clr_now) |=> (viol_flag && $stable(viol_addr)));

  assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_cnt == CNT_MAX) |=> (viol_cnt == CNT_MAX));

  assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(viol_cnt));
endmodule

bind addr_bounds_chk abc_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .en_q(en_q),
  .hit_any(hit_any), .clr_now(clr_now), .viol_flag(viol_flag),
  .viol_addr(viol_addr), .viol_cnt(viol_cnt)
);

// File: tb/addr_bounds_chk_tb.sv
module addr_bounds_chk_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0;
  logic [63:0] acc_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [63:0] cfg_data = '0;
  logic        viol_flag;
  logic [63:0] viol_addr;
  logic [15:0] viol_cnt;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench-side model
  logic [63:0] m_lo [3];
  logic [63:0] m_hi [3];
  bit          m_en;
  bit          m_flag;
  logic [63:0] m_addr;
  logic [15:0] m_cnt;

  addr_bounds_chk u_dut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_addr(acc_addr),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .viol_flag(viol_flag), .viol_addr(viol_addr), .viol_cnt(viol_cnt)
  );

  always #5 clk = ~clk;

  localparam int NV = 13;
  localparam logic [63:0] VEC_ADDR [NV] = '{
    64'h1000, 64'h1FFF, 64'h2000, 64'h0FFF, 64'h10000, 64'h1FFFF, 64'h20000,
    64'h8000_0000, 64'hFFFF_FFFF_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFEF,
    64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0
  };
  localparam bit VEC_BAD [NV] = '{
    1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1
  };

  function automatic bit m_inside(input logic [63:0] a);
    bit r = 0;
    for (int i = 0; i < 3; i++)
      if (m_lo[i] < m_hi[i] && a >= m_lo[i] && a < m_hi[i]) r = 1;
    return r;
  endfunction

  // One clock: drive at negedge, outputs settle after the posedge, back at next negedge.
  task automatic cyc(input bit wr, input logic [2:0] sel, input logic [63:0] data,
                     input bit vld, input logic [63:0] addr);
    bit miss, clr;
    @(negedge clk);
    cfg_wr = wr; cfg_sel = sel; cfg_data = data; acc_vld = vld; acc_addr = addr;
    miss = vld && m_en && !m_inside(addr);
    clr  = wr && sel == 3'd7;
    if (miss) begin
      if (!m_flag || clr) m_addr = addr;
      m_flag = 1;
      if (m_cnt != 16'hFFFF) m_cnt = m_cnt + 16'd1;
    end else if (clr) m_flag = 0;
    if (wr && sel < 3'd6) begin
      if (sel[0]) m_hi[sel >> 1] = data; else m_lo[sel >> 1] = data;
    end
    if (wr && sel == 3'd6) m_en = data[0];
    @(negedge clk);
    cfg_wr = 0; acc_vld = 0;
  endtask

  task automatic check(input string tag);
    total++;
    if (viol_flag !== m_flag || viol_addr !== m_addr || viol_cnt !== m_cnt) begin
      bad++;
      $display("FAIL %s: flag=%0b addr=%h cnt=%0d expected flag=%0b addr=%h cnt=%0d",
               tag, viol_flag, viol_addr, viol_cnt, m_flag, m_addr, m_cnt);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    m_en = 0; m_flag = 0; m_addr = '0; m_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset state");

    // disabled and empty: nothing flagged
    cyc(0, 0, 0, 1, 64'h1234);
    check("R9 R10 disabled after reset");
    // enabled, all regions empty
    cyc(1, 3'd6, 64'h1, 0, 0);
    cyc(0, 0, 0, 1, 64'h1234);
    check("R4 R10 empty regions flag");
    cyc(1, 3'd7, 0, 0, 0);
    check("R8 clear keeps count");

    // configure windows
    cyc(1, 3'd0, 64'h1000, 0, 0);
    cyc(1, 3'd1, 64'h2000, 0, 0);
    cyc(1, 3'd2, 64'h10000, 0, 0);
    cyc(1, 3'd3, 64'h20000, 0, 0);
    cyc(1, 3'd4, 64'hFFFF_FFFF_FFFF_0000, 0, 0);
    cyc(1, 3'd5, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0);
    check("R5 setup writes no effect");

    for (int v = 0; v < NV; v++) begin
      cyc(0, 0, 0, 1, VEC_ADDR[v]);
      check($sformatf("R1 R2 R3 R6 R11 vector %0d bad=%0b", v, VEC_BAD[v]));
    end
    total++;
    if (viol_addr !== 64'h2000) begin
      bad++;
      $display("FAIL R6: first latched addr=%h expected %h", viol_addr, 64'h2000);
    end

    // empty heap: lo == hi, then lo > hi
    cyc(1, 3'd7, 0, 0, 0);
    cyc(1, 3'd3, 64'h10000, 0, 0);
    cyc(0, 0, 0, 1, 64'h10000);
    check("R4 heap lo==hi empty");
    cyc(1, 3'd2, 64'h20000, 0, 0);
    cyc(0, 0, 0, 1, 64'h18000);
    check("R4 heap lo>hi empty");
    cyc(1, 3'd2, 64'h10000, 0, 0);
    cyc(1, 3'd3, 64'h20000, 0, 0);

    // same-cycle write and access
    cyc(1, 3'd7, 0, 0, 0);
    cyc(1, 3'd3, 64'h30000, 1, 64'h25000);
    check("R5 same-cycle access uses old limit");
    total++;
    if (!viol_flag) begin
      bad++;
      $display("FAIL R5: flag=%0b expected 1", viol_flag);
    end
    cyc(0, 0, 0, 1, 64'h25000);
    check("R5 new limit next cycle");

    // clear racing a violation
    cyc(1, 3'd7, 0, 1, 64'hDEAD_0000);
    check("R8 clear with violation relatches");
    cyc(0, 0, 0, 1, 64'hBEEF_0000);
    check("R6 later violation keeps address");

    // disabled checker ignores a miss
    cyc(1, 3'd7, 0, 0, 0);
    cyc(1, 3'd6, 64'h0, 0, 0);
    cyc(0, 0, 0, 1, 64'h5_0000_0000);
    check("R9 disabled miss ignored");

    // saturation
    cyc(1, 3'd6, 64'h1, 0, 0);
    @(negedge clk);
    acc_vld = 1; acc_addr = 64'h7777_0000;
    for (int k = 0; k < 66000; k++) begin
      if (!m_flag) m_addr = acc_addr;
      m_flag = 1;
      if (m_cnt != 16'hFFFF) m_cnt = m_cnt + 16'd1;
      @(negedge clk);
    end
    acc_vld = 0;
    check("R7 counter saturates");
    total++;
    if (viol_cnt !== 16'hFFFF) begin
      bad++;
      $display("FAIL R7: cnt=%0d expected 65535", viol_cnt);
    end
    cyc(0, 0, 0, 1, 64'h7777_0008);
    check("R7 stays at max");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule